// File: doc/BRIEF.md
# Interrupt Vector Register with Source Status

This block holds the 8-bit interrupt vector that a host reads when it services an interrupt. It has two modes, chosen by a status-merge control input. With the control clear, the register is plain read/write storage: the host reads back the byte it last wrote. With the control set, the upper four bits always come from the stored byte. The lower four bits then carry a code that names the highest-priority source now pending. A service routine can therefore branch on the vector directly.

A source counts as pending when its request line is high and its in-service flag is low. Sources are ranked by index, with index 0 the most urgent. The code for the winning source is its index shifted left by one place, so the least significant bit of the vector stays 0. When no source is pending in status mode, the stored byte is returned instead, with bit 0 still forced to 0. The vector output is formed combinationally from the stored byte and the live request lines. The host must expect it to change between an acknowledge and the read that follows, if a source that is not yet in service raises or drops its request in that interval.

Top module: `irq_vector_reg`

## Requirements
- R1: With the status-merge input low, the vector output equals the last byte written, all 8 bits.
- R2: With the status-merge input high and at least one source pending, the output is {stored[7:4], code}, where code = {winning index[2:0], 1'b0}.
- R3: With the status-merge input high and no source pending, the output is {stored[7:1], 1'b0}.
- R4: Bit 0 of the output is 0 whenever the status-merge input is high. With the input low, bit 0 reads back the written bit 0.
- R5: Among pending sources, the one with the lowest index wins. For example, sources 7 and 2 pending gives code 4'h4.
- R6: A source is pending only when its request is 1 and its in-service flag is 0. A source that is in service does not affect the output.
- R7: The output follows changes on the request and in-service inputs in the same cycle, with no clock edge needed.
- R8: A write stores all 8 bits in either mode. After a write made in status mode, switching to plain mode shows the full written byte, including bit 0.
- R9: Reset clears the stored byte to 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Store wr_data on the rising clock edge |
| wr_data | input | 8 | Byte to store |
| status_mode | input | 1 | 1 = merge the pending-source code into the low nibble |
| irq_req | input | NSRC | Request line of each source |
| irq_ius | input | NSRC | In-service flag of each source |
| vec_out | output | 8 | Vector as the host reads it |

## Verification
The bench targets the priority order with many pending sources, including sources 0 and 7. It also masks every requester through its in-service flag, and reads back bit 0 after the mode changes. A wrong priority encoder would return the code of a higher index. A mask that ignores in-service flags would show a code where the stored low nibble is expected. Forgetting to force bit 0 would let an odd written byte leak through in status mode. Masking the write in status mode would lose bit 0 when plain mode returns. Request changes are also applied between clock edges, so that a design that registers the status code shows a stale nibble.

// File: rtl/irq_vector_reg.sv
module irq_vector_reg #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic            status_mode,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_ius,
  output logic [7:0]      vec_out
);

  logic [7:0]      stored;
  logic [NSRC-1:0] pend;
  logic [2:0]      win_idx;
  logic            any_pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     stored <= 8'h00;
    else if (wr_en) stored <= wr_data;

  assign pend     = irq_req & ~irq_ius;
  assign any_pend = |pend;

  always_comb begin
    win_idx = 3'd0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) win_idx = 3'(i);
  end

  assign vec_out = !status_mode ? stored :
                   any_pend     ? {stored[7:4], win_idx, 1'b0} :
                                  {stored[7:1], 1'b0};

endmodule

module irq_vector_reg_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [7:0]      wr_data,
  input logic            status_mode,
  input logic [NSRC-1:0] irq_req,
  input logic [NSRC-1:0] irq_ius,
  input logic [7:0]      vec_out
);

  assert_plain_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !status_mode) |=> (status_mode || vec_out == $past(wr_data)));

  assert_bit0_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_mode |-> !vec_out[0]);

  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vec_out[7:4] == $past(wr_data[7:4]));

  assert_top_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && irq_req[0] && !irq_ius[0]) |-> vec_out[3:0] == 4'h0);

  assert_idle_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode && (irq_req & ~irq_ius) == '0 && $past(wr_en))
      |-> vec_out[3:1] == $past(wr_data[3:1]));

endmodule

bind irq_vector_reg irq_vector_reg_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .status_mode(status_mode), .irq_req(irq_req), .irq_ius(irq_ius),
  .vec_out(vec_out)
);

// File: tb/irq_vector_reg_tb.sv
module irq_vector_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, status_mode = 0;
  logic [7:0] wr_data = 0;
  logic [NSRC-1:0] irq_req = 0, irq_ius = 0;
  logic [7:0] vec_out;
  logic [7:0] model = 0;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_reg #(.NSRC(NSRC)) u_dut (.*);

  function automatic logic [7:0] expect_vec(logic [7:0] s, logic m,
                                            logic [NSRC-1:0] r, logic [NSRC-1:0] u);
    logic [NSRC-1:0] p;
    p = r & ~u;
    if (!m) return s;
    for (int i = 0; i < NSRC; i++)
      if (p[i]) return {s[7:4], 3'(i), 1'b0};
    return {s[7:1], 1'b0};
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    compared++;
    if (vec_out !== exp) begin
      mismatched++;
      $display("FAIL %s: vec_out=%h expected=%h", tag, vec_out, exp);
    end
  endtask

  task automatic step(logic w, logic [7:0] d, logic m,
                      logic [NSRC-1:0] r, logic [NSRC-1:0] u, string tag);
    @(negedge clk);
    wr_en = w; wr_data = d; status_mode = m; irq_req = r; irq_ius = u;
    #1 check(tag, expect_vec(model, m, r, u));
    @(posedge clk);
    if (w) model = d;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: expired expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    #1 check("R9 reset", 8'h00);
    @(negedge clk) rst_n = 1;
    step(0, 8'h00, 0, '0, '0, "R9 after reset");
    step(1, 8'hA5, 0, '0, '0, "R1 write");
    step(0, 8'h00, 0, 8'hFF, '0, "R1 plain ignores requests");
    step(0, 8'h00, 1, '0, '0, "R3 R4 no pending bit0 low");
    step(0, 8'h00, 1, 8'hFF, '0, "R5 source 0 wins");
    step(0, 8'h00, 1, 8'h84, '0, "R5 source 2 over 7");
    step(0, 8'h00, 1, 8'h80, '0, "R2 source 7 code E");
    step(0, 8'h00, 1, 8'h03, 8'h01, "R6 in-service masked");
    step(0, 8'h00, 1, 8'h3C, 8'h3C, "R6 all masked");
    step(1, 8'h5B, 1, '0, '0, "R8 write in status mode");
    step(0, 8'h00, 1, '0, '0, "R3 odd byte bit0 forced");
    step(0, 8'h00, 0, '0, '0, "R8 R4 plain shows bit0");
    @(negedge clk);
    status_mode = 1; irq_req = 8'h10; irq_ius = 0;
    #1 check("R7 comb follow a", expect_vec(model, 1, 8'h10, 0));
    irq_req = 8'h12;
    #1 check("R7 comb follow b", expect_vec(model, 1, 8'h12, 0));
    irq_ius = 8'h02;
    #1 check("R7 R6 comb ius", expect_vec(model, 1, 8'h12, 8'h02));
    for (int k = 0; k < 600; k++)
      step(1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom & $urandom),
           8'($urandom), "R2 random");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule